// File: doc/BRIEF.md
# Cartridge Save-Memory Mapping Controller

This block sits on a 24-bit byte-addressed main bus and decides what happens to accesses that land in the cartridge save-memory window. It keeps a small control register and works out from the first accesses whether the cartridge carries parallel SRAM or a serial EEPROM. It then steers each byte access to the SRAM port, or to a pending-command interface that feeds a separate serial EEPROM engine. The serial bit protocol is not part of this block. The engine only sees two strobes: "execute the held command" and "replace the held command".

The save window starts as 0x200000 to 0x20FFFF. The first write into the window fixes the save type. If that write targets 0x200000 or 0x200001, the block enters EEPROM mode and shrinks the window to those two bytes. A read above 0x200001 while SRAM reads are enabled and the type is still open marks the memory as plain SRAM.

In EEPROM mode, writes that arrive close together are merged. A write that comes less than a set number of cycles of a free-running counter after the last executed write only refreshes the held command.

Decisions within a cycle use the control state from before that cycle's clock edge. All port outputs are combinational from the current inputs and that state. The state changes at the rising edge on which a strobe is sampled.

Top module: `save_map_ctrl`

## Requirements
- R1: A byte write to address 0xA130F1 replaces control bit 0 (SRAM read enable) and bit 1 (SRAM write protect) with data bits 0 and 1. The EEPROM-mode bit and the type-detected bit keep their values.
- R2: After reset:
  - the control register is all zero;
  - the window is 0x200000 to 0x20FFFF;
  - the dirty flag is low;
  - the EEPROM timestamp is zero;
  - with no strobe, every output is low.
- R3: A write into the window while the type is undetected always sets the detected bit.
  - If that write's address is 0x200000 or 0x200001, EEPROM mode is also set and the window becomes 0x200000 to 0x200001.
  - The write itself is handled with the pre-write control state.
- R4: A read into the window at an address above 0x200001, with read enable set and the type undetected, sets the detected bit without setting EEPROM mode. Reads at 0x200001 or below, and reads with read enable clear, never set it.
- R5: In EEPROM mode, a write in the window always pulses the update strobe and presents the address bit 0 and the data.
  - The execute strobe also pulses, and the timestamp takes the counter value, only when (counter minus timestamp) modulo 2^32 is at least 46.
  - Below 46, the write only updates the held command.
- R6: Outside EEPROM mode, a window write asserts the SRAM select.
  - The SRAM write enable is asserted only when protect is clear and the stored byte differs from the write data.
  - Each such write sets a sticky dirty flag.
- R7: A window read in EEPROM mode returns the EEPROM data bit in data bit 0, with bits 7:1 zero and the hit flag set.
  - Otherwise, a window read returns the SRAM byte with the hit flag set only when read enable is set. Otherwise the hit flag and data are zero.
- R8: An access outside the window produces no SRAM select, write enable, EEPROM strobe, hit or state change. Only the control-register write of R1 is an exception.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 8 | Write data byte |
| bus_wr | input | 1 | Byte write strobe, one cycle per access |
| bus_rd | input | 1 | Byte read strobe, one cycle per access |
| cyc_cnt | input | 32 | Free-running bus cycle counter |
| sram_rdata | input | 8 | Byte currently stored at sram_addr (combinational read) |
| ee_dout | input | 1 | Data bit from the serial EEPROM engine |
| sram_cs | output | 1 | SRAM select |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 16 | Offset of the access within the window |
| sram_wdata | output | 8 | SRAM write data |
| ee_exec | output | 1 | Execute the held EEPROM command |
| ee_upd | output | 1 | Load a new held EEPROM command |
| ee_pend_a0 | output | 1 | Address bit 0 of the new held command |
| ee_pend_data | output | 8 | Data of the new held command |
| rd_hit | output | 1 | This block drives the read data |
| rd_data | output | 8 | Read data |
| save_dirty | output | 1 | Sticky flag: SRAM contents changed |

## Verification
Two functions can fall on the very first window write. Type detection, which may switch to EEPROM mode and narrow the window, coincides with that write's own SRAM store, and the store must still follow the pre-write state. The bench provokes this by writing 0x200001 right after reset with differing data. It expects an SRAM write enable and no EEPROM strobe in that cycle. The next write, at 0x200000, is then expected to behave as an EEPROM access with no SRAM select. The same overlap is checked with equal data (no write enable) and with a first write elsewhere in the window, which must leave the block in SRAM mode.

// File: rtl/save_map_pkg.sv
package save_map_pkg;
  // Control state kept by the block; bit positions of the bus-visible
  // register matter only for bits 0 and 1, which the control write loads.
  typedef struct packed {
    logic detected;  // save type fixed
    logic ee_mode;   // serial EEPROM routing
    logic wprot;     // SRAM write protect (bus bit 1)
    logic rd_en;     // SRAM read enable   (bus bit 0)
  } save_ctrl_t;

  localparam int BUS_AW  = 24;
  localparam int DATA_W  = 8;
endpackage

// File: rtl/save_win_decode.sv
module save_win_decode #(
  parameter int AW    = 24,
  parameter int OFF_W = 16
) (
  input  logic [AW-1:0]    addr,
  input  logic [AW-1:0]    win_lo,
  input  logic [AW-1:0]    win_hi,
  output logic             in_win,
  output logic             above_pair,
  output logic             on_pair,
  output logic [OFF_W-1:0] offset
);
  // Pair of byte addresses that select EEPROM mode on first write.
  localparam logic [AW-1:0] PAIR_BASE = AW'(24'h200000);
  localparam logic [AW-1:0] PAIR_TOP  = PAIR_BASE | AW'(1);

  always_comb begin
    in_win     = (addr >= win_lo) && (addr <= win_hi);
    above_pair = addr > PAIR_TOP;
    on_pair    = (addr[AW-1:1] == PAIR_BASE[AW-1:1]);
    offset     = addr[OFF_W-1:0] - win_lo[OFF_W-1:0];
  end
endmodule

// File: rtl/save_ctrl_reg.sv
module save_ctrl_reg
  import save_map_pkg::*;
#(
  parameter int              AW     = 24,
  parameter logic [AW-1:0]   DEF_LO = AW'(24'h200000),
  parameter logic [AW-1:0]   DEF_HI = AW'(24'h20FFFF)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,      // control register write
  input  logic [1:0]    ctl_bits,
  input  logic          wr_first,    // window write while undetected
  input  logic          wr_on_pair,
  input  logic          rd_sram_det, // qualifying read while undetected
  output save_ctrl_t    ctrl,
  output logic [AW-1:0] win_lo,
  output logic [AW-1:0] win_hi
);
  localparam logic [AW-1:0] PAIR_LO = AW'(24'h200000);
  localparam logic [AW-1:0] PAIR_HI = PAIR_LO | AW'(1);

  save_ctrl_t    ctrl_d;
  logic [AW-1:0] lo_d, hi_d;
  logic          en;

  always_comb begin
    ctrl_d = ctrl;
    lo_d   = win_lo;
    hi_d   = win_hi;
    if (ctl_wr) begin
      ctrl_d.rd_en = ctl_bits[0];
      ctrl_d.wprot = ctl_bits[1];
    end
    if (wr_first) begin
      ctrl_d.detected = 1'b1;
      if (wr_on_pair) begin
        ctrl_d.ee_mode = 1'b1;
        lo_d           = PAIR_LO;
        hi_d           = PAIR_HI;
      end
    end
    if (rd_sram_det) ctrl_d.detected = 1'b1;
  end

  assign en = ctl_wr | wr_first | rd_sram_det;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      win_lo <= DEF_LO;
      win_hi <= DEF_HI;
    end else if (en) begin
      ctrl   <= ctrl_d;
      win_lo <= lo_d;
      win_hi <= hi_d;
    end
  end

  // R1: control write loads bits 0/1 and keeps the type bits
  assert_ctl_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |=> (ctrl.rd_en == $past(ctl_bits[0])) && (ctrl.wprot == $past(ctl_bits[1]))
               && (ctrl.ee_mode == $past(ctrl.ee_mode)));

  // R3: detected bit is sticky until reset
  assert_det_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.detected |=> ctrl.detected);

  // R3: EEPROM mode only ever comes with a two-byte window
  assert_pair_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl.ee_mode |-> (win_hi == win_lo + AW'(1)) && ctrl.detected);

  // R4: read detection never selects EEPROM mode
  assert_rd_det_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sram_det && !ctrl.ee_mode) |=> !ctrl.ee_mode && ctrl.detected);
endmodule

// File: rtl/save_ee_gate.sv
module save_ee_gate #(
  parameter int CYC_W = 32,
  parameter int WIN   = 46
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,   // EEPROM-mode window write
  input  logic [CYC_W-1:0] cyc,
  output logic             exec_o,
  output logic             upd_o
);
  localparam logic [CYC_W-1:0] WIN_C = CYC_W'(WIN);

  logic [CYC_W-1:0] ts_q, ts_d, dt;
  logic             late;

  always_comb begin
    dt     = cyc - ts_q;
    late   = dt >= WIN_C;
    upd_o  = wr_hit;
    exec_o = wr_hit & late;
    ts_d   = cyc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ts_q <= '0;
    else if (exec_o) ts_q <= ts_d;
  end

  // R5: execute never comes without a new held command
  assert_exec_pairs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |-> upd_o);

  // R5: an executed write restarts the window at its own counter value
  assert_ts_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_o |=> (ts_q == $past(cyc)));
endmodule

// File: rtl/save_map_ctrl.sv
module save_map_ctrl
  import save_map_pkg::*;
#(
  parameter int                  CYC_W     = 32,
  parameter int                  EE_WIN    = 46,
  parameter int                  OFF_W     = 16,
  parameter logic [BUS_AW-1:0]   CTL_ADDR  = 24'hA130F1,
  parameter logic [BUS_AW-1:0]   WIN_LO    = 24'h200000,
  parameter logic [BUS_AW-1:0]   WIN_HI    = 24'h20FFFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [BUS_AW-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [CYC_W-1:0]   cyc_cnt,
  input  logic [DATA_W-1:0]  sram_rdata,
  input  logic               ee_dout,
  output logic               sram_cs,
  output logic               sram_we,
  output logic [OFF_W-1:0]   sram_addr,
  output logic [DATA_W-1:0]  sram_wdata,
  output logic               ee_exec,
  output logic               ee_upd,
  output logic               ee_pend_a0,
  output logic [DATA_W-1:0]  ee_pend_data,
  output logic               rd_hit,
  output logic [DATA_W-1:0]  rd_data,
  output logic               save_dirty
);
  // reset: asserted at once, released after two clock edges
  logic [1:0] rs_q;
  logic       rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q_n = rs_q[1];

  save_ctrl_t        ctrl;
  logic [BUS_AW-1:0] win_lo, win_hi;
  logic              in_win, above_pair, on_pair;
  logic              ctl_wr, wr_first, rd_sram_det;
  logic              win_wr, win_rd, ee_wr, differs;
  logic              dirty_d;

  save_win_decode #(.AW(BUS_AW), .OFF_W(OFF_W)) u_dec (
    .addr       (bus_addr),
    .win_lo     (win_lo),
    .win_hi     (win_hi),
    .in_win     (in_win),
    .above_pair (above_pair),
    .on_pair    (on_pair),
    .offset     (sram_addr)
  );

  always_comb begin
    win_wr      = bus_wr & in_win;
    win_rd      = bus_rd & in_win;
    ctl_wr      = bus_wr & (bus_addr == CTL_ADDR);
    wr_first    = win_wr & ~ctrl.detected;
    rd_sram_det = win_rd & ctrl.rd_en & ~ctrl.detected & above_pair;
    ee_wr       = win_wr & ctrl.ee_mode;
    differs     = sram_rdata != bus_wdata;
  end

  save_ctrl_reg #(.AW(BUS_AW), .DEF_LO(WIN_LO), .DEF_HI(WIN_HI)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .ctl_wr      (ctl_wr),
    .ctl_bits    (bus_wdata[1:0]),
    .wr_first    (wr_first),
    .wr_on_pair  (on_pair),
    .rd_sram_det (rd_sram_det),
    .ctrl        (ctrl),
    .win_lo      (win_lo),
    .win_hi      (win_hi)
  );

  save_ee_gate #(.CYC_W(CYC_W), .WIN(EE_WIN)) u_ee (
    .clk    (clk),
    .rst_n  (rst_q_n),
    .wr_hit (ee_wr),
    .cyc    (cyc_cnt),
    .exec_o (ee_exec),
    .upd_o  (ee_upd)
  );

  // SRAM and read path
  always_comb begin
    sram_cs      = ~ctrl.ee_mode & (win_wr | (win_rd & ctrl.rd_en));
    sram_we      = ~ctrl.ee_mode & win_wr & ~ctrl.wprot & differs;
    sram_wdata   = bus_wdata;
    ee_pend_a0   = bus_addr[0];
    ee_pend_data = bus_wdata;
    rd_hit       = win_rd & (ctrl.ee_mode | ctrl.rd_en);
    if (!rd_hit)           rd_data = '0;
    else if (ctrl.ee_mode) rd_data = {{(DATA_W-1){1'b0}}, ee_dout};
    else                   rd_data = sram_rdata;
    dirty_d      = save_dirty | sram_we;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n)     save_dirty <= 1'b0;
    else if (sram_we) save_dirty <= dirty_d;
  end

  // R6: no SRAM store while protected or routed to the EEPROM
  assert_we_gate_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    sram_we |-> sram_cs && !ctrl.wprot && !ctrl.ee_mode && (sram_rdata != bus_wdata));

  // R6: a store leaves the dirty flag set
  assert_dirty_set_R6: assert property (@(posedge clk) disable iff (!rst_q_n)
    sram_we |=> save_dirty);

  // R8: nothing outside the window reaches the save memories
  assert_outside_quiet_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    !in_win |-> !sram_cs && !ee_upd && !ee_exec && !rd_hit);

  // R7: EEPROM and SRAM never share a cycle
  assert_route_excl_R7: assert property (@(posedge clk) disable iff (!rst_q_n)
    !(sram_cs && (ee_upd || (rd_hit && ctrl.ee_mode))));
endmodule

// File: tb/sim_save_map_ctrl.sv
`timescale 1ns/1ps
module sim_save_map_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] bus_addr;
  logic [7:0]  bus_wdata;
  logic        bus_wr, bus_rd;
  logic [31:0] cyc_cnt;
  logic [7:0]  sram_rdata;
  logic        ee_dout;
  logic        sram_cs, sram_we, ee_exec, ee_upd, ee_pend_a0, rd_hit, save_dirty;
  logic [15:0] sram_addr;
  logic [7:0]  sram_wdata, ee_pend_data, rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  save_map_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .cyc_cnt(cyc_cnt), .sram_rdata(sram_rdata),
    .ee_dout(ee_dout), .sram_cs(sram_cs), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .ee_exec(ee_exec), .ee_upd(ee_upd),
    .ee_pend_a0(ee_pend_a0), .ee_pend_data(ee_pend_data), .rd_hit(rd_hit),
    .rd_data(rd_data), .save_dirty(save_dirty)
  );

  typedef struct packed {
    logic [1:0]  op;    // 0 idle, 1 read, 2 write, 3 reset
    logic [23:0] a;
    logic [7:0]  wd;
    logic [31:0] cyc;
    logic [7:0]  sq;
    logic        eb;
    logic [4:0]  fl;    // expected {cs, we, exec, upd, hit}
    logic [7:0]  rd;
    logic        dirty;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t VEC [0:NV-1] = '{
    '{2'd1, 24'h200010, 8'h00, 32'd0,   8'h5A, 1'b0, 5'b00000, 8'h00, 1'b0, 4'd7}, // R7 read disabled
    '{2'd2, 24'hA130F1, 8'hFD, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b0, 4'd1}, // R1 enable reads
    '{2'd1, 24'h200010, 8'h00, 32'd0,   8'h5A, 1'b0, 5'b10001, 8'h5A, 1'b0, 4'd4}, // R4 read detects SRAM
    '{2'd2, 24'h200000, 8'h11, 32'd10,  8'h22, 1'b0, 5'b11000, 8'h00, 1'b0, 4'd3}, // R3 already detected
    '{2'd2, 24'h200004, 8'h33, 32'd0,   8'h33, 1'b0, 5'b10000, 8'h00, 1'b1, 4'd6}, // R6 same data
    '{2'd2, 24'hA130F1, 8'h03, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b1, 4'd1}, // R1 protect
    '{2'd2, 24'h200004, 8'h44, 32'd0,   8'h00, 1'b0, 5'b10000, 8'h00, 1'b1, 4'd6}, // R6 protected
    '{2'd2, 24'h300000, 8'h12, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b1, 4'd8}, // R8 write outside
    '{2'd1, 24'h300000, 8'h00, 32'd0,   8'h99, 1'b0, 5'b00000, 8'h00, 1'b1, 4'd8}, // R8 read outside
    '{2'd1, 24'h20FFFF, 8'h00, 32'd0,   8'h77, 1'b0, 5'b10001, 8'h77, 1'b1, 4'd7}, // R7 top of window
    '{2'd1, 24'h210000, 8'h00, 32'd0,   8'h77, 1'b0, 5'b00000, 8'h00, 1'b1, 4'd8}, // R8 just above
    '{2'd2, 24'hA130F1, 8'h00, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b1, 4'd1}, // R1 clear both
    '{2'd1, 24'h200010, 8'h00, 32'd0,   8'h66, 1'b0, 5'b00000, 8'h00, 1'b1, 4'd7}, // R7 disabled again
    '{2'd2, 24'h200000, 8'h01, 32'd20,  8'h00, 1'b0, 5'b11000, 8'h00, 1'b1, 4'd1}, // R1 type bits kept
    '{2'd3, 24'h000000, 8'h00, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b0, 4'd2}, // R2
    '{2'd2, 24'h200001, 8'h80, 32'd100, 8'h00, 1'b0, 5'b11000, 8'h00, 1'b0, 4'd3}, // R3 pair write, old state
    '{2'd2, 24'h200000, 8'h01, 32'd120, 8'h00, 1'b0, 5'b00110, 8'h00, 1'b1, 4'd5}, // R5 exec
    '{2'd2, 24'h200000, 8'h02, 32'd150, 8'h00, 1'b0, 5'b00010, 8'h00, 1'b1, 4'd5}, // R5 dt 30
    '{2'd2, 24'h200001, 8'h03, 32'd165, 8'h00, 1'b0, 5'b00010, 8'h00, 1'b1, 4'd5}, // R5 dt 45
    '{2'd2, 24'h200000, 8'h04, 32'd166, 8'h00, 1'b0, 5'b00110, 8'h00, 1'b1, 4'd5}, // R5 dt 46
    '{2'd1, 24'h200001, 8'h00, 32'd0,   8'hAA, 1'b1, 5'b00001, 8'h01, 1'b1, 4'd7}, // R7 ee bit 1
    '{2'd1, 24'h200001, 8'h00, 32'd0,   8'hAA, 1'b0, 5'b00001, 8'h00, 1'b1, 4'd7}, // R7 ee bit 0
    '{2'd1, 24'h200002, 8'h00, 32'd0,   8'hAA, 1'b1, 5'b00000, 8'h00, 1'b1, 4'd3}, // R3 narrowed
    '{2'd2, 24'h200002, 8'h09, 32'd400, 8'h00, 1'b0, 5'b00000, 8'h00, 1'b1, 4'd3}, // R3 narrowed write
    '{2'd2, 24'hA130F1, 8'h01, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b1, 4'd1}, // R1
    '{2'd1, 24'h200000, 8'h00, 32'd0,   8'h55, 1'b1, 5'b00001, 8'h01, 1'b1, 4'd7}, // R7 ee over sram
    '{2'd3, 24'h000000, 8'h00, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b0, 4'd2}, // R2
    '{2'd1, 24'h200010, 8'h00, 32'd0,   8'h12, 1'b0, 5'b00000, 8'h00, 1'b0, 4'd4}, // R4 no detect w/o enable
    '{2'd2, 24'h200000, 8'h05, 32'd7,   8'h05, 1'b0, 5'b10000, 8'h00, 1'b0, 4'd3}, // R3 becomes EEPROM
    '{2'd2, 24'h200000, 8'h06, 32'd9,   8'h00, 1'b0, 5'b00010, 8'h00, 1'b0, 4'd5}, // R5 dt 9 from reset ts
    '{2'd3, 24'h000000, 8'h00, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b0, 4'd2}, // R2
    '{2'd2, 24'h200010, 8'h01, 32'd0,   8'h00, 1'b0, 5'b11000, 8'h00, 1'b0, 4'd3}, // R3 first write elsewhere
    '{2'd2, 24'h200000, 8'h02, 32'd50,  8'h00, 1'b0, 5'b11000, 8'h00, 1'b1, 4'd3}, // R3 stays SRAM
    '{2'd2, 24'hA130F1, 8'h01, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b1, 4'd1}, // R1
    '{2'd1, 24'h200100, 8'h00, 32'd0,   8'h3C, 1'b0, 5'b10001, 8'h3C, 1'b1, 4'd4}, // R4 wide window kept
    '{2'd3, 24'h000000, 8'h00, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b0, 4'd2}, // R2
    '{2'd2, 24'hA130F1, 8'h01, 32'd0,   8'h00, 1'b0, 5'b00000, 8'h00, 1'b0, 4'd1}, // R1
    '{2'd1, 24'h200001, 8'h00, 32'd0,   8'h10, 1'b0, 5'b10001, 8'h10, 1'b0, 4'd4}, // R4 at pair: no detect
    '{2'd2, 24'h200000, 8'h00, 32'd30,  8'h00, 1'b0, 5'b10000, 8'h00, 1'b0, 4'd4}, // R4 still open -> EEPROM
    '{2'd2, 24'h200000, 8'h07, 32'd200, 8'h00, 1'b0, 5'b00110, 8'h00, 1'b0, 4'd5}  // R5 exec
  };

  task automatic check(input string tag, input logic [4:0] fl, input logic [7:0] rd,
                       input logic dirty);
    logic [13:0] act, exp;
    act = {sram_cs, sram_we, ee_exec, ee_upd, rd_hit, rd_data, save_dirty};
    exp = {fl, rd, dirty};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: {cs,we,exec,upd,hit,rd,dirty} actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
  endtask

  task automatic access(input logic [1:0] op, input logic [23:0] a, input logic [7:0] wd,
                        input logic [31:0] cyc, input logic [7:0] sq, input logic eb);
    @(negedge clk);
    bus_addr = a; bus_wdata = wd; cyc_cnt = cyc; sram_rdata = sq; ee_dout = eb;
    bus_rd = (op == 2'd1); bus_wr = (op == 2'd2);
    #2;
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    rst_n = 0; cyc_cnt = '0; sram_rdata = '0; ee_dout = 0;
    idle();
    repeat (2) @(posedge clk);
    #2;
    check("R2 in reset", 5'b00000, 8'h00, 1'b0);
    @(negedge clk); rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    #2;
    check("R2 after reset idle", 5'b00000, 8'h00, 1'b0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i].op == 2'd3) begin
        @(negedge clk);
        idle();
        rst_n = 0;
        #2;
        check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].fl, VEC[i].rd, VEC[i].dirty);
        @(negedge clk);
        rst_n = 1;
        repeat (3) @(posedge clk);
      end else begin
        access(VEC[i].op, VEC[i].a, VEC[i].wd, VEC[i].cyc, VEC[i].sq, VEC[i].eb);
        check($sformatf("R%0d row %0d", VEC[i].req, i), VEC[i].fl, VEC[i].rd, VEC[i].dirty);
      end
    end

    // R5: counter wrap is handled modulo 2^32
    do_reset();
    access(2'd2, 24'h200000, 8'h00, 32'd5, 8'h00, 1'b0);
    check("R3 pair write before wrap", 5'b10000, 8'h00, 1'b0);
    access(2'd2, 24'h200000, 8'h21, 32'hFFFF_FFF0, 8'h00, 1'b0);
    check("R5 exec near top", 5'b00110, 8'h00, 1'b0);
    access(2'd2, 24'h200001, 8'h22, 32'h0000_000A, 8'h00, 1'b0);
    check("R5 wrapped dt 26", 5'b00010, 8'h00, 1'b0);
    n_chk++;
    if (ee_pend_a0 !== 1'b1 || ee_pend_data !== 8'h22) begin
      n_bad++;
      $display("FAIL R5 pending fields: actual a0=%b data=%h expected a0=1 data=22",
               ee_pend_a0, ee_pend_data);
    end
    access(2'd2, 24'h200000, 8'h23, 32'h0000_001E, 8'h00, 1'b0);
    check("R5 wrapped dt 46", 5'b00110, 8'h00, 1'b0);

    // R6: offset presented to SRAM
    do_reset();
    access(2'd2, 24'h201234, 8'h5F, 32'd0, 8'h00, 1'b0);
    n_chk++;
    if (sram_addr !== 16'h1234 || sram_wdata !== 8'h5F || sram_we !== 1'b1) begin
      n_bad++;
      $display("FAIL R6 sram port: actual addr=%h data=%h we=%b expected 1234 5F 1",
               sram_addr, sram_wdata, sram_we);
    end
    @(negedge clk); idle(); #2;
    check("R6 dirty after store", 5'b00000, 8'h00, 1'b1);

    summary();
  end
endmodule